// File: doc/BRIEF.md
# Extended-Address Memory Board Select

This block decides, for every bus access, whether the access falls on this memory board. It compares the upper eight bits of a 24-bit bus address against a strapped region number, which places the board in one of 256 regions of 64K. It can also require bit 15 to match a strap so that a half-size build occupies only the lower or upper 32K of that region. A 4-bit magnitude comparison against a strapped 4K block number can cut a hole at that block, or disable everything below it or everything above it. An optional phantom input can switch the board off.

The block has two outputs. `fast_sel` takes no account of bus status, so the chip-select decoder can start as early as possible. It may therefore assert during I/O or interrupt-acknowledge cycles. `qual_sel` is `fast_sel` gated by the memory-cycle qualifier, and it enables the read drivers and the sixteen-bit acknowledge. Both outputs are purely combinational, and the block holds no state.

Top module: `board_select_top`

## Requirements
- R1: With `cfg_ext_en`=1, `fast_sel` can be 1 only when `bus_addr[23:16]` equals `cfg_region`.
- R2: With `cfg_ext_en`=0, neither `bus_addr[23:16]` nor `cfg_region` affects either output.
- R3: With `cfg_half_en`=1, `fast_sel` requires `bus_addr[15]` to equal `cfg_half_sel`. With `cfg_half_en`=0, bit 15 takes no part in the region match.
- R4: With `cfg_win_mode`=2'b01 (below), accesses whose `bus_addr[15:12]` is less than `cfg_blk` are deselected. The strapped block itself stays enabled.
- R5: With `cfg_win_mode`=2'b10 (at), only accesses whose `bus_addr[15:12]` equals `cfg_blk` are deselected.
- R6: With `cfg_win_mode`=2'b11 (above), accesses whose `bus_addr[15:12]` is greater than `cfg_blk` are deselected. The strapped block itself stays enabled.
- R7: With `cfg_win_mode`=2'b00 (off), nothing is deselected by the window, and `cfg_blk` has no effect.
- R8: With `cfg_phan_en`=1, `phantom_n`=0 forces both `fast_sel` and `qual_sel` to 0. With `cfg_phan_en`=0, `phantom_n` has no effect.
- R9: `fast_sel` does not depend on `mem_cycle`. `qual_sel` equals `fast_sel` AND `mem_cycle`.
- R10: The block-disable number is counted from the start of the 64K region. The half-size strap does not offset it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 24 | Bus address |
| mem_cycle | input | 1 | Status qualifier, 1 during a memory cycle |
| phantom_n | input | 1 | Active-low phantom |
| cfg_ext_en | input | 1 | Strap: compare upper address byte |
| cfg_region | input | 8 | Strap: 64K region number |
| cfg_half_en | input | 1 | Strap: half-size (32K) build |
| cfg_half_sel | input | 1 | Strap: 32K half, 0 lower, 1 upper |
| cfg_blk | input | 4 | Strap: 4K block number for the window |
| cfg_win_mode | input | 2 | Strap: 00 off, 01 below, 10 at, 11 above |
| cfg_phan_en | input | 1 | Strap: honour phantom |
| fast_sel | output | 1 | Unqualified board select |
| qual_sel | output | 1 | Memory-cycle-qualified board select |

## Verification
The bench builds the block with its default widths: a 24-bit address, an 8-bit region number and a 4-bit block number. With these widths the real 4K-block edges are reachable, for example 3FFF/4000, BFFF/C000 and the E000–EFFF hole. Region mismatches above and below the strap are also reachable, as is the interaction of the half strap with block numbering, which lets the block-relative-to-region rule be shown on actual addresses.

// File: rtl/board_select_pkg.sv
package board_select_pkg;

    typedef enum logic [1:0] {
        WIN_OFF   = 2'b00,
        WIN_BELOW = 2'b01,
        WIN_AT    = 2'b10,
        WIN_ABOVE = 2'b11
    } win_mode_e;

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int REGION_W = 8
) (
    input  logic [REGION_W-1:0] addr_hi,
    input  logic                half_bit,
    input  logic                ext_en,
    input  logic [REGION_W-1:0] region,
    input  logic                half_en,
    input  logic                half_sel,
    output logic                hit
);
    logic region_ok;
    logic half_ok;

    always_comb begin
        region_ok = !ext_en || (addr_hi == region);
        half_ok   = !half_en || (half_bit == half_sel);
        hit       = region_ok && half_ok;
    end
endmodule

// File: rtl/block_window.sv
module block_window
    import board_select_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [BLK_W-1:0] blk_cfg,
    input  win_mode_e        mode,
    output logic             kill
);
    always_comb begin
        unique case (mode)
            WIN_BELOW: kill = (blk_addr <  blk_cfg);
            WIN_AT:    kill = (blk_addr == blk_cfg);
            WIN_ABOVE: kill = (blk_addr >  blk_cfg);
            default:   kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/board_select_top.sv
module board_select_top
    import board_select_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int REGION_W = 8,
    parameter int BLK_W    = 4
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                mem_cycle,
    input  logic                phantom_n,
    input  logic                cfg_ext_en,
    input  logic [REGION_W-1:0] cfg_region,
    input  logic                cfg_half_en,
    input  logic                cfg_half_sel,
    input  logic [BLK_W-1:0]    cfg_blk,
    input  logic [1:0]          cfg_win_mode,
    input  logic                cfg_phan_en,
    output logic                fast_sel,
    output logic                qual_sel
);
    localparam int REGION_LSB = ADDR_W - REGION_W;
    localparam int HALF_BIT   = REGION_LSB - 1;
    localparam int BLK_LSB    = REGION_LSB - BLK_W;

    logic      region_hit;
    logic      win_kill;
    logic      phan_block;
    win_mode_e win_mode;

    assign win_mode = win_mode_e'(cfg_win_mode);

    region_match #(.REGION_W(REGION_W)) u_region (
        .addr_hi (bus_addr[ADDR_W-1:REGION_LSB]),
        .half_bit(bus_addr[HALF_BIT]),
        .ext_en  (cfg_ext_en),
        .region  (cfg_region),
        .half_en (cfg_half_en),
        .half_sel(cfg_half_sel),
        .hit     (region_hit)
    );

    block_window #(.BLK_W(BLK_W)) u_window (
        .blk_addr(bus_addr[REGION_LSB-1:BLK_LSB]),
        .blk_cfg (cfg_blk),
        .mode    (win_mode),
        .kill    (win_kill)
    );

    always_comb begin
        phan_block = cfg_phan_en && !phantom_n;
        fast_sel   = region_hit && !win_kill && !phan_block;
        qual_sel   = fast_sel && mem_cycle;
    end

    always_comb begin
        // R9
        qual_implies_fast_chk: assert (!qual_sel || fast_sel);
        // R8
        phantom_off_chk: assert (!(cfg_phan_en && !phantom_n) || (!fast_sel && !qual_sel));
        // R1
        region_miss_chk: assert (!(cfg_ext_en && bus_addr[ADDR_W-1:REGION_LSB] != cfg_region) || !fast_sel);
        // R3
        half_miss_chk: assert (!(cfg_half_en && bus_addr[HALF_BIT] != cfg_half_sel) || !fast_sel);
        // R6
        above_kill_chk: assert (!(cfg_win_mode == 2'b11 && bus_addr[REGION_LSB-1:BLK_LSB] > cfg_blk) || !fast_sel);
        // R7
        off_pass_chk: assert (!(cfg_win_mode == 2'b00 && region_hit && !phan_block) || fast_sel);
    end
endmodule

// File: tb/tb_board_select_top.sv
module tb_board_select_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr;
    logic        mem_cycle, phantom_n, cfg_ext_en, cfg_half_en, cfg_half_sel, cfg_phan_en;
    logic [7:0]  cfg_region;
    logic [3:0]  cfg_blk;
    logic [1:0]  cfg_win_mode;
    logic        fast_sel, qual_sel;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    board_select_top dut (
        .bus_addr(bus_addr), .mem_cycle(mem_cycle), .phantom_n(phantom_n),
        .cfg_ext_en(cfg_ext_en), .cfg_region(cfg_region), .cfg_half_en(cfg_half_en),
        .cfg_half_sel(cfg_half_sel), .cfg_blk(cfg_blk), .cfg_win_mode(cfg_win_mode),
        .cfg_phan_en(cfg_phan_en), .fast_sel(fast_sel), .qual_sel(qual_sel)
    );

    task automatic defaults();
        bus_addr = 24'h0; mem_cycle = 1'b1; phantom_n = 1'b1;
        cfg_ext_en = 1'b0; cfg_region = 8'h0; cfg_half_en = 1'b0; cfg_half_sel = 1'b0;
        cfg_blk = 4'h0; cfg_win_mode = 2'b00; cfg_phan_en = 1'b0;
    endtask

    task automatic expect_sel(string req, logic [23:0] addr, logic exp_fast, logic exp_qual);
        @(negedge clk);
        bus_addr = addr;
        #1;
        checks++;
        if (fast_sel !== exp_fast || qual_sel !== exp_qual) begin
            errors++;
            $display("FAIL %s addr=%h fast=%b qual=%b expected fast=%b qual=%b",
                     req, addr, fast_sel, qual_sel, exp_fast, exp_qual);
        end
    endtask

    task automatic t_reset();
        defaults(); mem_cycle = 1'b0;
        expect_sel("R9 reset", 24'h001234, 1'b1, 1'b0);
    endtask

    task automatic t_ext_on();
        defaults(); cfg_ext_en = 1'b1; cfg_region = 8'h01;
        expect_sel("R1 match", 24'h012345, 1'b1, 1'b1);
        expect_sel("R1 above", 24'h022345, 1'b0, 1'b0);
        expect_sel("R1 below", 24'h002345, 1'b0, 1'b0);
    endtask

    task automatic t_ext_off();
        defaults(); cfg_region = 8'h01;
        expect_sel("R2 high bits", 24'hFF2345, 1'b1, 1'b1);
        cfg_region = 8'h77;
        expect_sel("R2 strap", 24'h3C2345, 1'b1, 1'b1);
    endtask

    task automatic t_half();
        defaults(); cfg_half_en = 1'b1; cfg_half_sel = 1'b1;
        expect_sel("R3 upper", 24'h008000, 1'b1, 1'b1);
        expect_sel("R3 lower", 24'h007FFF, 1'b0, 1'b0);
        cfg_half_en = 1'b0;
        expect_sel("R3 full", 24'h007FFF, 1'b1, 1'b1);
    endtask

    task automatic t_below();
        defaults(); cfg_win_mode = 2'b01; cfg_blk = 4'h4;
        expect_sel("R4 under", 24'h003FFF, 1'b0, 1'b0);
        expect_sel("R4 at", 24'h004000, 1'b1, 1'b1);
        expect_sel("R4 top", 24'h00FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_at();
        defaults(); cfg_win_mode = 2'b10; cfg_blk = 4'hE;
        expect_sel("R5 start", 24'h00E000, 1'b0, 1'b0);
        expect_sel("R5 end", 24'h00EFFF, 1'b0, 1'b0);
        expect_sel("R5 before", 24'h00DFFF, 1'b1, 1'b1);
        expect_sel("R5 after", 24'h00F000, 1'b1, 1'b1);
    endtask

    task automatic t_above();
        defaults(); cfg_win_mode = 2'b11; cfg_blk = 4'hB;
        expect_sel("R6 at", 24'h00BFFF, 1'b1, 1'b1);
        expect_sel("R6 over", 24'h00C000, 1'b0, 1'b0);
        expect_sel("R6 top", 24'h00FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_off();
        defaults();
        for (int b = 0; b < 16; b += 5) begin
            cfg_blk = 4'(b);
            expect_sel("R7 off", 24'h005000, 1'b1, 1'b1);
        end
    endtask

    task automatic t_phantom();
        defaults(); cfg_phan_en = 1'b1; phantom_n = 1'b0;
        expect_sel("R8 active", 24'h001000, 1'b0, 1'b0);
        phantom_n = 1'b1;
        expect_sel("R8 idle", 24'h001000, 1'b1, 1'b1);
        cfg_phan_en = 1'b0; phantom_n = 1'b0;
        expect_sel("R8 ignored", 24'h001000, 1'b1, 1'b1);
    endtask

    task automatic t_status();
        defaults(); mem_cycle = 1'b0;
        expect_sel("R9 io cycle", 24'h002000, 1'b1, 1'b0);
        mem_cycle = 1'b1;
        expect_sel("R9 mem cycle", 24'h002000, 1'b1, 1'b1);
    endtask

    task automatic t_relative();
        defaults(); cfg_ext_en = 1'b1; cfg_region = 8'h05;
        cfg_half_en = 1'b1; cfg_half_sel = 1'b1; cfg_win_mode = 2'b01; cfg_blk = 4'h9;
        expect_sel("R10 block 8", 24'h058FFF, 1'b0, 1'b0);
        expect_sel("R10 block 9", 24'h059000, 1'b1, 1'b1);
    endtask

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset(); t_ext_on(); t_ext_off(); t_half(); t_below(); t_at();
        t_above(); t_off(); t_phantom(); t_status(); t_relative();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule